// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block models the write side of a byte-wide nonvolatile array that is reprogrammed one sector at a time. It runs in a single synchronous clock domain and takes active-low chip-select, read-strobe and write-strobe inputs that are already sampled in that domain, together with an 18-bit byte address and 8-bit data. Qualified write strobes deposit bytes into a 256-byte page buffer. Every byte must belong to the sector selected by the first byte of the load phase. Bytes may arrive in any order.

No explicit command ends a load phase. When no new write has begun for a programmable number of cycles after the last one finished, the block enters a timed internal cycle. During this cycle the target sector is erased and rewritten from the page buffer, and a busy flag is raised. Reads during the cycle return a status byte: the inverted top bit of the last loaded byte, plus a bit that flips on every read. Once the cycle ends, reads return array contents again.

The array keeps 2**STORE_SECT_W sectors. Sector numbers beyond that range alias onto the stored ones by their low bits.

Top module: `sp_sector_prog`

## Requirements
- R1: After a synchronous reset, busy is 0, dout_en is 0 and dout is 0.
- R2: A read is sampled when cs_n=0, rd_n=1 and wr_n... more precisely cs_n=0, rd_n=0 and wr_n=1 at a clock edge. After that edge dout_en is 1 and dout holds the addressed byte. When no read is sampled, dout_en is 0. Array bytes that were never programmed read 0xFF.
- R3: A byte is loaded only when cs_n=0, wr_n=0 and rd_n=1 are sampled for at least MIN_PULSE consecutive edges. Shorter pulses, and write strobes with rd_n=0, change nothing.
- R4: A load takes its address from the first edge of the strobe pulse. It takes its data from the last edge before the strobe is released.
- R5: The program cycle begins (busy rises) WIN_CYC cycles after the release of the last accepted load, unless a new matching load starts first.
- R6: Address bits 17..8 give the sector and bits 7..0 give the byte. A load whose sector differs from the first load of the phase is ignored, and it does not restart the window timer.
- R7: Bytes may be loaded in any order. A byte loaded twice keeps the later value.
- R8: When the cycle ends, each loaded byte of the target sector holds its loaded value and each unloaded byte holds 0xFF. Other sectors are unchanged.
- R9: Busy stays high for PROG_CYC cycles and then falls.
- R10: While busy, a read returns {~L[7], T, L[5:0]}, where L is the last loaded byte. T resets to 0 and inverts at the first edge of each read that starts while busy. Once busy has fallen, reads return true data.
- R11: Write strobes while busy load nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low; a write needs it high |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 18 | Byte address: sector in 17..8, byte in 7..0 |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status |
| dout_en | output | 1 | dout carries a valid read result |
| busy | output | 1 | Internal erase/program cycle in progress |

## Verification
The bench builds the block with WIN_CYC=40, PROG_CYC=400, MIN_PULSE=2 and STORE_SECT_W=3. These short timers let the bench reach both the window expiry and the end of the program cycle within a few hundred cycles, so it can check busy just before and just after each boundary. MIN_PULSE=2 makes a one-cycle write strobe the glitch case. Eight stored sectors are enough to show that a program leaves its neighbours untouched.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_st_t;

endpackage

// File: rtl/sp_wr_qual.sv
// Write strobe qualifier: rejects short pulses, captures address at pulse start
// and data at the last strobe-low cycle.
module sp_wr_qual #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ld_start,
  output logic              ld_end,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic              raw;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign raw = !cs_n && !wr_n && rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (raw) begin
        if (cnt != CW'(MIN_PULSE)) cnt <= cnt + CW'(1);
        if (cnt == '0) addr_q <= addr;
        data_q <= din;
      end else begin
        cnt <= '0;
      end
    end
  end

  assign ld_start = raw && (cnt == CW'(MIN_PULSE - 1));
  assign ld_end   = !raw && (cnt == CW'(MIN_PULSE));
  assign ld_addr  = (cnt == '0) ? addr : addr_q;
  assign ld_data  = data_q;

  // R3: a low read strobe blocks any load start
  a_r3_rd_blocks_start: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ld_start);
  // R3: a load ends only after a qualified strobe was present the cycle before
  a_r3_end_after_strobe: assert property (@(posedge clk) disable iff (rst)
    ld_end |-> ($past(!cs_n) && $past(!wr_n)));

endmodule

// File: rtl/sp_page_buf.sv
// Page buffer with per-byte loaded mask and registered read port.
module sp_page_buf #(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [BYTE_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTE_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int PAGE = 2 ** BYTE_W;

  logic [DATA_W-1:0] mem [PAGE];
  logic [PAGE-1:0]   mask;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      rvalid <= 1'b0;
    end else begin
      if (clr)     mask       <= '0;
      else if (we) mask[widx] <= 1'b1;
      rvalid <= mask[ridx];
    end
  end

  // R7: every buffered byte is marked loaded on the following cycle
  a_r7_mask_marks_load: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> mask[$past(widx)]);

endmodule

// File: rtl/sp_array.sv
// Storage array: one write port, one registered read port, erased at start.
module sp_array #(
  parameter int AW     = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sp_sector_prog.sv
module sp_sector_prog
  import sp_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 8,
  parameter int BYTE_W       = 8,
  parameter int STORE_SECT_W = 3,
  parameter int MIN_PULSE    = 2,
  parameter int WIN_CYC      = 15000,
  parameter int PROG_CYC     = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int SECT_W   = ADDR_W - BYTE_W;
  localparam int PAGE     = 2 ** BYTE_W;
  localparam int STORE_AW = STORE_SECT_W + BYTE_W;
  localparam int WCW      = $clog2(WIN_CYC + 1);
  localparam int PCW      = $clog2(PROG_CYC + 1);

  if (PROG_CYC < PAGE + 2) begin : g_prog_too_short
    $error("PROG_CYC must cover the page copy");
  end

  // load qualifier
  logic              ld_start, ld_end;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;

  sp_wr_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din),
    .ld_start(ld_start), .ld_end(ld_end), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  // sequencer state
  seq_st_t           state;
  logic [SECT_W-1:0] sect_q;
  logic [BYTE_W-1:0] byte_q;
  logic              acc_q;
  logic [WCW-1:0]    win_cnt;
  logic [PCW-1:0]    pcnt;
  logic [BYTE_W-1:0] widx_q;
  logic              last_hi_q;
  logic [DATA_W-3:0] last_lo_q;
  logic              busy_q;

  logic start_match, buf_clr, buf_we;

  assign start_match = ld_start &&
    ((state == ST_IDLE) ||
     ((state == ST_LOAD) && (ld_addr[ADDR_W-1:BYTE_W] == sect_q)));
  assign buf_clr = (state == ST_IDLE) && ld_start;
  assign buf_we  = (state == ST_LOAD) && ld_end && acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sect_q    <= '0;
      byte_q    <= '0;
      acc_q     <= 1'b0;
      win_cnt   <= '0;
      pcnt      <= '0;
      widx_q    <= '0;
      last_hi_q <= 1'b0;
      last_lo_q <= '0;
      busy_q    <= 1'b0;
    end else begin
      widx_q <= pcnt[BYTE_W-1:0];
      unique case (state)
        ST_IDLE: begin
          if (ld_start) begin
            state   <= ST_LOAD;
            sect_q  <= ld_addr[ADDR_W-1:BYTE_W];
            byte_q  <= ld_addr[BYTE_W-1:0];
            acc_q   <= 1'b1;
            win_cnt <= '0;
          end
        end
        ST_LOAD: begin
          if (start_match) begin
            acc_q  <= 1'b1;
            byte_q <= ld_addr[BYTE_W-1:0];
          end else if (buf_we) begin
            acc_q     <= 1'b0;
            win_cnt   <= '0;
            last_hi_q <= ld_data[DATA_W-1];
            last_lo_q <= ld_data[DATA_W-3:0];
          end else if (!acc_q) begin
            if (win_cnt == WCW'(WIN_CYC - 1)) begin
              state  <= ST_PROG;
              pcnt   <= '0;
              busy_q <= 1'b1;
            end else begin
              win_cnt <= win_cnt + WCW'(1);
            end
          end
        end
        ST_PROG: begin
          if (pcnt == PCW'(PROG_CYC - 1)) begin
            state  <= ST_IDLE;
            busy_q <= 1'b0;
            acc_q  <= 1'b0;
          end else begin
            pcnt <= pcnt + PCW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // page buffer
  logic [DATA_W-1:0] buf_rdata;
  logic              buf_rvalid;

  sp_page_buf #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we),
    .widx(byte_q), .wdata(ld_data),
    .ridx(pcnt[BYTE_W-1:0]), .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  // array: sector rewritten byte by byte, one cycle behind the buffer read
  logic                arr_we;
  logic [STORE_AW-1:0] arr_waddr, arr_raddr;
  logic [DATA_W-1:0]   arr_wdata, arr_rdata;

  assign arr_we    = (state == ST_PROG) && (pcnt >= PCW'(1)) && (pcnt <= PCW'(PAGE));
  assign arr_waddr = {sect_q[STORE_SECT_W-1:0], widx_q};
  assign arr_wdata = buf_rvalid ? buf_rdata : '1;
  assign arr_raddr = {addr[BYTE_W+STORE_SECT_W-1:BYTE_W], addr[BYTE_W-1:0]};

  sp_array #(.AW(STORE_AW), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  // read path and busy status
  logic              rd_cond, rd_q, rd_start, tog_q, tog_nx;
  logic              en_q, sel_q;
  logic [DATA_W-1:0] stat_q;

  assign rd_cond  = !cs_n && !rd_n && wr_n;
  assign rd_start = rd_cond && !rd_q;
  assign tog_nx   = tog_q ^ (busy_q && rd_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      tog_q  <= 1'b0;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      rd_q   <= rd_cond;
      tog_q  <= tog_nx;
      en_q   <= rd_cond;
      sel_q  <= busy_q;
      stat_q <= {~last_hi_q, tog_nx, last_lo_q};
    end
  end

  assign dout    = !en_q ? '0 : (sel_q ? stat_q : arr_rdata);
  assign dout_en = en_q;
  assign busy    = busy_q;

  // R11: nothing enters the page buffer while busy
  a_r11_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !buf_we);
  // R8: the array is written only inside the program cycle
  a_r8_write_in_cycle: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy_q);
  // R5: busy rises only when the load window has run out
  a_r5_window_expired: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(win_cnt) == WCW'(WIN_CYC - 1)));
  // R9: busy falls only at the end of the program time
  a_r9_full_cycle: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(pcnt) == PCW'(PROG_CYC - 1)));
  // R2: a sampled read yields a valid output next cycle
  a_r2_read_valid: assert property (@(posedge clk) disable iff (rst)
    rd_cond |=> dout_en);
  // R10: busy status carries the inverted top bit of the last loaded byte
  a_r10_status_msb: assert property (@(posedge clk) disable iff (rst)
    (en_q && sel_q) |-> (dout[DATA_W-1] != last_hi_q));

endmodule

// File: tb/sp_sector_prog_tb.sv
module sp_sector_prog_tb_top;
  localparam int WIN  = 40;
  localparam int PROG = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, busy;

  int checks = 0, failures = 0, cyc = 0;
  logic tog_m = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sp_sector_prog #(
    .ADDR_W(18), .DATA_W(8), .BYTE_W(8), .STORE_SECT_W(3),
    .MIN_PULSE(2), .WIN_CYC(WIN), .PROG_CYC(PROG)
  ) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every valid read result
  always @(negedge clk) begin
    if (!rst && dout_en) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 unexpected read actual=%h expected=none", dout);
      end else begin
        check(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  function automatic logic [7:0] stat(input logic [7:0] l, input logic t);
    return {~l[7], t, l[5:0]};
  endfunction

  task automatic rd(input logic [17:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic rd_stat(input logic [17:0] a, input logic [7:0] l, input string tag);
    tog_m = ~tog_m;
    rd(a, stat(l, tog_m), tag);
  endtask

  // write pulse: first cycle a0/d0, later cycles a1, last cycle d1
  task automatic wr(input logic [17:0] a0, input logic [17:0] a1,
                    input logic [7:0] d0, input logic [7:0] d1,
                    input int len, input logic rdn);
    @(posedge clk); #1;
    cs_n = 1'b0; wr_n = 1'b0; rd_n = rdn; addr = a0; din = (len == 1) ? d1 : d0;
    for (int i = 1; i < len; i++) begin
      @(posedge clk); #1;
      addr = a1; din = (i == len - 1) ? d1 : d0;
    end
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t0, t1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 dout_en", {7'd0, dout_en}, 8'h00);
    check("R1 dout", dout, 8'h00);

    rd(18'h00005, 8'hFF, "R2 erased read");
    // chip select high: no read result
    @(posedge clk); #1; cs_n = 1'b1; rd_n = 1'b0; wr_n = 1'b1;
    @(posedge clk); #2;
    check("R2 no read when deselected", {7'd0, dout_en}, 8'h00);
    rd_n = 1'b1;

    // phase A: sector 1, out of order, overwrite, glitch, blocked strobe
    wr(18'h00110, 18'h00110, 8'h3C, 8'h3C, 3, 1'b1);
    wr(18'h00102, 18'h001F3, 8'h00, 8'hA5, 3, 1'b1);   // R4 address first, data last
    wr(18'h00120, 18'h00120, 8'h11, 8'h11, 1, 1'b1);   // R3 short pulse
    wr(18'h00121, 18'h00121, 8'h22, 8'h22, 3, 1'b0);   // R3 read strobe low
    wr(18'h00110, 18'h00110, 8'h7E, 8'h7E, 3, 1'b1);   // R7 overwrite
    t0 = cyc;
    wr(18'h00230, 18'h00230, 8'h99, 8'h99, 3, 1'b1);   // R6 foreign sector
    wait_to(t0 + WIN - 2);
    check("R5 idle before window end", {7'd0, busy}, 8'h00);
    wait_to(t0 + WIN + 4);
    check("R6 window not restarted by foreign sector", {7'd0, busy}, 8'h01);
    wr(18'h00140, 18'h00140, 8'h55, 8'h55, 3, 1'b1);   // R11 load while busy
    rd_stat(18'h00110, 8'h7E, "R10 status read 1");
    rd_stat(18'h00110, 8'h7E, "R10 status read 2");
    wait_to(t0 + WIN + PROG - 6);
    check("R9 busy held", {7'd0, busy}, 8'h01);
    wait_to(t0 + WIN + PROG + 6);
    check("R9 busy released", {7'd0, busy}, 8'h00);
    rd(18'h00110, 8'h7E, "R7 later value kept");
    rd(18'h00102, 8'hA5, "R4 data from last cycle");
    rd(18'h001F3, 8'hFF, "R4 late address not used");
    rd(18'h00120, 8'hFF, "R3 short pulse ignored");
    rd(18'h00121, 8'hFF, "R3 blocked strobe ignored");
    rd(18'h00140, 8'hFF, "R11 busy load ignored");
    rd(18'h00230, 8'hFF, "R6 foreign sector untouched");
    rd(18'h00005, 8'hFF, "R8 other sector untouched");
    rd(18'h00110, 8'h7E, "R10 true data after cycle");

    // phase B: sector 0, last byte with top bit set
    wr(18'h00005, 18'h00005, 8'h81, 8'h81, 2, 1'b1);
    t1 = cyc;
    wait_to(t1 + WIN + 4);
    rd_stat(18'h00005, 8'h81, "R10 status with top bit set");
    wait_to(t1 + WIN + PROG + 6);
    rd(18'h00005, 8'h81, "R8 loaded byte");
    rd(18'h00006, 8'hFF, "R8 unloaded byte erased");
    rd(18'h00110, 8'h7E, "R8 previous sector kept");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule